// File: doc/BRIEF.md
# Four-Level Symbol Frame Sync Detector and Word Packer

This block sits behind a four-level FM demodulator that hands over one decoded symbol at a time. Each symbol is a 2-bit level code plus a 6-bit soft quality figure, and it arrives with a one-cycle strobe. At the nominal rate of 4800 symbols per second the strobes are far apart in clock cycles. The block keeps a sliding window of the most recent symbol codes and compares it with a programmable 24-symbol frame sync pattern. When the window matches, it emits a one-cycle sync pulse.

Once a sync has been seen, every following symbol is turned into a byte made of its code above its quality. Successive bytes are paired into 16-bit words for the host bus, giving 2400 words per second, and each finished word is announced by a one-cycle valid strobe. Packing always starts again on the symbol after a sync match. A half-filled word therefore never spans a sync word. The search keeps running while words are being produced, so a later sync re-aligns the pairing.

Top module: `c4fm_sync_packer`

## Requirements
- R1: While and right after reset, `word_valid` and `sync_found` are low and `word_data` is zero.
- R2: `sync_found` is high for exactly the one cycle after a strobe whose code completes a match. A match means the newest 24 codes (this one included) equal `sync_pattern`, where bits [47:46] hold the oldest symbol and bits [1:0] the newest.
- R3: No match is reported until at least 24 strobes have been taken since reset, even when the pattern equals the reset contents of the window.
- R4: A window that differs from the pattern in any single symbol produces no `sync_found`.
- R5: Before the first sync match after reset, no word is produced, whatever symbols arrive.
- R6: After a sync match, every second symbol strobe raises `word_valid` in the following cycle. The word is then {first code, first quality, second code, second quality}, with the first code in [15:14], its quality in [13:8], the second code in [7:6] and its quality in [5:0].
- R7: The symbol that completes a match is not packed. A pending half word is dropped at the match, and the next two symbols form the next word.
- R8: Code and quality inputs have no effect while `sym_valid` is low.
- R9: `word_valid` lasts one cycle, and `word_data` keeps the last word until the next one is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | One-cycle strobe marking a new symbol |
| sym_code | input | 2 | Decoded four-level symbol code |
| sym_qual | input | 6 | Soft quality figure of the symbol |
| sync_pattern | input | 48 | Sync pattern, oldest symbol in the top two bits |
| word_data | output | 16 | Packed pair of symbols |
| word_valid | output | 1 | One-cycle strobe for a new word |
| sync_found | output | 1 | One-cycle pulse on a sync match |

## Verification
A table of symbol pairs drives the packer with extreme codes and qualities (all zeros against all ones) and with alternating bit patterns in both fields. This separates a swapped byte order from swapped code and quality fields. The sync search is tried with the exact pattern, with the same pattern carrying one corrupted symbol, and with an all-zero pattern straight after reset, which catches a window that matches before it has been filled. A second sync sent while half a word is pending, plus junk on the inputs with the strobe low, shows whether the pairing re-aligns correctly or drifts.

// File: rtl/c4fm_sync_pkg.sv
package c4fm_sync_pkg;

    localparam int CODE_W    = 2;
    localparam int QUAL_W    = 6;
    localparam int SYM_W     = CODE_W + QUAL_W;
    localparam int WORD_W    = 2 * SYM_W;
    localparam int SYNC_SYMS = 24;
    localparam int PAT_W     = SYNC_SYMS * CODE_W;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [QUAL_W-1:0] qual;
    } sym_t;

    typedef enum logic [1:0] {
        PH_HUNT   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } pack_phase_e;

    function automatic logic [WORD_W-1:0] join_pair(input sym_t older, input sym_t newer);
        return {older, newer};
    endfunction

endpackage

// File: rtl/c4fm_sym_history.sv
module c4fm_sym_history #(
    parameter int DEPTH = 24,
    parameter int CW    = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    shift_en,
    input  logic [CW-1:0]           code_in,
    output logic [(DEPTH-1)*CW-1:0] window,
    output logic                    primed
);
    localparam int PRIOR  = DEPTH - 1;
    localparam int VEC_W  = PRIOR * CW;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] fill_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            window   <= '0;
            fill_cnt <= '0;
        end else if (shift_en) begin
            window <= {window[VEC_W-CW-1:0], code_in};
            if (fill_cnt != CNT_W'(PRIOR))
                fill_cnt <= fill_cnt + 1'b1;
        end
    end

    assign primed = (fill_cnt == CNT_W'(PRIOR));

    // R8: the window only moves on a strobe
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(window));

    // R3: priming never regresses without reset
    p_primed_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        primed |=> primed);

endmodule

// File: rtl/c4fm_sync_match.sv
module c4fm_sync_match #(
    parameter int DEPTH = 24,
    parameter int CW    = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sym_valid,
    input  logic [CW-1:0]           code_in,
    input  logic [(DEPTH-1)*CW-1:0] window,
    input  logic                    primed,
    input  logic [DEPTH*CW-1:0]     pattern,
    output logic                    hit,
    output logic                    found
);
    logic [DEPTH*CW-1:0] candidate;
    logic [DEPTH-1:0]    sym_eq;

    assign candidate = {window, code_in};

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign sym_eq[g] = (candidate[g*CW +: CW] == pattern[g*CW +: CW]);
    end

    assign hit = sym_valid && primed && (&sym_eq);

    always_ff @(posedge clk) begin
        if (rst) found <= 1'b0;
        else     found <= hit;
    end

    // R2: a sync pulse always follows a symbol strobe
    p_found_on_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        found |-> $past(sym_valid));

    // R3: no pulse from a window that was not yet filled
    p_found_primed_r3: assert property (@(posedge clk) disable iff (rst)
        found |-> $past(primed));

endmodule

// File: rtl/c4fm_word_packer.sv
module c4fm_word_packer
    import c4fm_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sym_valid,
    input  sym_t              sym_in,
    input  logic              sync_hit,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid
);
    pack_phase_e phase;
    sym_t        held;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_HUNT;
            held       <= '0;
            word_data  <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (sync_hit) begin
                phase <= PH_FIRST;
            end else if (sym_valid) begin
                unique case (phase)
                    PH_FIRST: begin
                        held  <= sym_in;
                        phase <= PH_SECOND;
                    end
                    PH_SECOND: begin
                        word_data  <= join_pair(held, sym_in);
                        word_valid <= 1'b1;
                        phase      <= PH_FIRST;
                    end
                    default: phase <= PH_HUNT;
                endcase
            end
        end
    end

    // R6: a word is only produced on a symbol strobe
    p_word_on_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(sym_valid));

    // R5: a word needs the second half of a pair while locked
    p_no_word_hunting_r5: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(phase) == PH_SECOND);

    // R7: a sync match restarts pairing and emits nothing
    p_realign_r7: assert property (@(posedge clk) disable iff (rst)
        sync_hit |=> (phase == PH_FIRST) && !word_valid);

    // R9: the word holds between strobes
    p_word_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !word_valid |-> $stable(word_data));

endmodule

// File: rtl/c4fm_sync_packer.sv
module c4fm_sync_packer
    import c4fm_sync_pkg::*;
#(
    parameter int SYNC_LEN = SYNC_SYMS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sym_valid,
    input  logic [CODE_W-1:0]          sym_code,
    input  logic [QUAL_W-1:0]          sym_qual,
    input  logic [SYNC_LEN*CODE_W-1:0] sync_pattern,
    output logic [WORD_W-1:0]          word_data,
    output logic                       word_valid,
    output logic                       sync_found
);
    localparam int HIST_W = (SYNC_LEN - 1) * CODE_W;

    logic [HIST_W-1:0] window;
    logic              primed;
    logic              hit;
    sym_t              sym_in;

    assign sym_in = '{code: sym_code, qual: sym_qual};

    c4fm_sym_history #(.DEPTH(SYNC_LEN), .CW(CODE_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (sym_valid),
        .code_in  (sym_code),
        .window   (window),
        .primed   (primed)
    );

    c4fm_sync_match #(.DEPTH(SYNC_LEN), .CW(CODE_W)) u_match (
        .clk       (clk),
        .rst       (rst),
        .sym_valid (sym_valid),
        .code_in   (sym_code),
        .window    (window),
        .primed    (primed),
        .pattern   (sync_pattern),
        .hit       (hit),
        .found     (sync_found)
    );

    c4fm_word_packer u_pack (
        .clk        (clk),
        .rst        (rst),
        .sym_valid  (sym_valid),
        .sym_in     (sym_in),
        .sync_hit   (hit),
        .word_data  (word_data),
        .word_valid (word_valid)
    );

    // R1/R5: both strobes stay low right after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> !word_valid && !sync_found);

endmodule

// File: tb/tb_c4fm_sync_packer.sv
`timescale 1ns/1ps
module tb_c4fm_sync_packer;

    localparam logic [47:0] PAT_A = 48'h5575_F5FF_77FF;
    localparam int NPAIR = 6;
    // {codeA, qualA, codeB, qualB, expected word}
    localparam logic [31:0] PAIRS [NPAIR] = '{
        {2'd0, 6'h00, 2'd3, 6'h3F, 16'h00FF},
        {2'd3, 6'h3F, 2'd0, 6'h00, 16'hFF00},
        {2'd1, 6'h2A, 2'd2, 6'h15, 16'h6A95},
        {2'd2, 6'h01, 2'd1, 6'h3E, 16'h817E},
        {2'd3, 6'h00, 2'd1, 6'h00, 16'hC040},
        {2'd0, 6'h3F, 2'd2, 6'h20, 16'h3FA0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sym_valid = 1'b0;
    logic [1:0]  sym_code = '0;
    logic [5:0]  sym_qual = '0;
    logic [47:0] sync_pattern = PAT_A;
    logic [15:0] word_data;
    logic        word_valid;
    logic        sync_found;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] o_word;
    logic        o_wv;
    logic        o_sf;

    always #2 clk = ~clk;

    c4fm_sync_packer dut (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_code(sym_code),
        .sym_qual(sym_qual), .sync_pattern(sync_pattern),
        .word_data(word_data), .word_valid(word_valid), .sync_found(sync_found)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sample();
        o_word = word_data;
        o_wv   = word_valid;
        o_sf   = sync_found;
    endtask

    task automatic send(input logic [1:0] c, input logic [5:0] q);
        @(negedge clk);
        sym_valid = 1'b1;
        sym_code  = c;
        sym_qual  = q;
        @(posedge clk);
        #1;
        sym_valid = 1'b0;
        sym_code  = ~c;
        sym_qual  = ~q;
        sample();
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
        sample();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    // send a 24-symbol pattern, optionally corrupting one position
    task automatic send_pattern(input logic [47:0] p, input int bad, input bit check_each);
        for (int i = 0; i < 24; i++) begin
            logic [1:0] c;
            c = p[47 - 2*i -: 2];
            if (i == bad) c = c ^ 2'b01;
            send(c, 6'(i));
            if (check_each || i == 23)
                chk((bad >= 0) ? "R4 corrupted pattern" : "R2 sync on last symbol",
                    {15'b0, o_sf}, {15'b0, (i == 23 && bad < 0)});
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        @(posedge clk); #1;
        sample();
        chk("R1 word_valid in reset", {15'b0, o_wv}, 16'h0);
        chk("R1 sync_found in reset", {15'b0, o_sf}, 16'h0);
        do_reset();
        idle();
        chk("R1 word_data after reset", o_word, 16'h0000);
        chk("R1 strobes after reset", {14'b0, o_wv, o_sf}, 16'h0);

        // R5: nothing packed before sync
        for (int i = 0; i < 4; i++) begin
            send(2'(i), 6'h2A);
            chk("R5 no word before sync", {15'b0, o_wv}, 16'h0);
        end

        // R4: one symbol wrong -> no sync, still no words (R5)
        send_pattern(PAT_A, 10, 1'b1);
        send(2'd1, 6'h01);
        send(2'd2, 6'h02);
        chk("R5 no word after failed sync", {15'b0, o_wv}, 16'h0);

        // R2: exact pattern
        send_pattern(PAT_A, -1, 1'b1);
        chk("R7 match symbol not packed", {15'b0, o_wv}, 16'h0);
        idle();
        chk("R2 sync pulse one cycle", {15'b0, o_sf}, 16'h0);

        // R6/R9: table of pairs
        for (int k = 0; k < NPAIR; k++) begin
            logic [31:0] v;
            v = PAIRS[k];
            send(v[31:30], v[29:24]);
            chk("R6 no word on first half", {15'b0, o_wv}, 16'h0);
            send(v[23:22], v[21:16]);
            chk("R6 word valid on second half", {15'b0, o_wv}, 16'h1);
            chk("R6 word content", o_word, v[15:0]);
            idle();
            chk("R9 word_valid one cycle", {15'b0, o_wv}, 16'h0);
            chk("R9 word held", o_word, v[15:0]);
        end

        // R8: junk with strobe low is ignored
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            sym_code = 2'(j);
            sym_qual = 6'(j * 7);
            @(posedge clk); #1;
            sample();
            chk("R8 no word on idle junk", {14'b0, o_wv, o_sf}, 16'h0);
        end
        send(2'd2, 6'h11);
        chk("R8 pairing not shifted", {15'b0, o_wv}, 16'h0);
        send(2'd1, 6'h22);
        chk("R8 word after junk", o_word, 16'h9162);

        // R7: resync with half word pending (23 packed symbols leave one held)
        send_pattern(PAT_A, -1, 1'b0);
        chk("R7 no word on resync symbol", {15'b0, o_wv}, 16'h0);
        send(2'd0, 6'h0A);
        chk("R7 pending half dropped", {15'b0, o_wv}, 16'h0);
        send(2'd3, 6'h30);
        chk("R7 realigned word valid", {15'b0, o_wv}, 16'h1);
        chk("R7 realigned word", o_word, 16'h0AF0);

        // R3: all-zero pattern must wait for a full window
        sync_pattern = '0;
        do_reset();
        for (int i = 0; i < 23; i++) begin
            send(2'd0, 6'h00);
            chk("R3 no sync before window full", {15'b0, o_sf}, 16'h0);
        end
        send(2'd0, 6'h00);
        chk("R3 sync at 24th symbol", {15'b0, o_sf}, 16'h1);
        send(2'd0, 6'h00);
        chk("R2 sync again on sliding match", {15'b0, o_sf}, 16'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule